// File: doc/BRIEF.md
# DMA Control Register File

This block is the software-visible register bank of a memory-to-memory DMA controller. It sits behind a 32-bit AXI4-Lite slave port and holds the control word, the status word, the current and tail descriptor pointers, the source and destination addresses and the transfer byte count. The data mover, the descriptor engine and the interrupt coalescing counters live elsewhere. They read the stored values from the output ports and report back through an idle flag, event-set inputs and the live counter values that are folded into the status word.

Besides storing values, the block decodes register writes into start pulses. A byte-count write starts a simple transfer when scatter-gather mode is off. A tail-pointer write starts the descriptor engine when scatter-gather mode is on. Which half of the tail pointer fires the start depends on the address width. The parameter `ADDR_BITS` selects 32-bit or 64-bit addressing. With 32-bit addressing, the upper-half registers do not exist.

A control write can request a soft reset. Other control writes follow masking and hold rules. When scatter-gather mode is left off, the descriptor pointers are cleared.

Top module: `dmareg_top`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0x00010002. With the idle input at 1, the threshold count input at 1, the delay count input at 0 and no events, the status register (offset 0x04) reads 0x0001000A.
- R2: A control write with bit 2 set restores every register to its reset value and discards the rest of the written word: the control word, both pointers, source, destination, byte count and all stored status bits. `softRst` pulses high for one cycle, in the cycle after the write handshake.
- R3: A control write without bit 2 stores only the bits under mask 0xFFFF707C, and bit 1 always reads as 1. The stored control word is visible on `ctrlWord`.
- R4: A control write whose bits 23:16 are zero keeps the previously stored threshold in bits 23:16.
- R5: A control write with bit 3 (scatter-gather mode) at 0 clears status bit 13 and both descriptor pointers. While bit 3 is 0, writes to offsets 0x08, 0x0C, 0x10 and 0x14 are ignored.
- R6: A write to the low half of a descriptor pointer (0x08 current, 0x10 tail) stores bits 5:0 as zero.
- R7: The byte-count register at 0x28 keeps bits 25:0 and reads the upper bits as 0. A write to it while control bit 3 is 0 raises `simpleStart` for exactly one cycle, the cycle after the write handshake. No pulse is raised while bit 3 is 1.
- R8: While control bit 3 is 1, a tail-pointer write raises `sgStart` for exactly one cycle, the cycle after the write handshake. With `ADDR_BITS`=32 the low-half write (0x10) fires it. With wider addressing only the high-half write (0x14) fires it.
- R9: With `ADDR_BITS`=32, the high-half offsets 0x0C, 0x14, 0x1C and 0x24 read 0 and writes to them are dropped.
- R10: Status layout: bit 1 = idle input, bit 3 = 1, bits 6:4 = sticky data errors, bits 10:8 = sticky descriptor errors, bits 14:12 = pending interrupts, bits 23:16 = threshold count input, bits 31:24 = delay count input. The set inputs set the sticky bits. Writing 1 to bits 14:12 clears them. A write has no effect on any other status bit.
- R11: The slave handles one transaction at a time. A write is accepted when the address and the data are both valid, and a write takes priority over a read. `bValid` or `rValid` rises the cycle after acceptance and holds until it is taken. Every response is OKAY (00). An unmapped offset reads 0.
- R12: The source address (0x18 low, 0x1C high) and the destination address (0x20 low, 0x24 high) store and read back the full written value, with no alignment applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| awAddr | input | 6 | Write byte offset |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| wData | input | 32 | Write data |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| bResp | output | 2 | Write response code, always OKAY |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| arAddr | input | 6 | Read byte offset |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response code, always OKAY |
| engIdle | input | 1 | Engine idle flag, shown in status bit 1 |
| irqSet | input | 3 | Set pending interrupt bits 14:12 |
| dmaErrSet | input | 3 | Set sticky data error bits 6:4 |
| sgErrSet | input | 3 | Set sticky descriptor error bits 10:8 |
| thrCount | input | 8 | Live threshold count, status bits 23:16 |
| dlyCount | input | 8 | Live delay count, status bits 31:24 |
| ctrlWord | output | 32 | Stored control word |
| curDesc | output | ADDR_BITS | Current descriptor pointer |
| tailDesc | output | ADDR_BITS | Tail descriptor pointer |
| srcAddr | output | ADDR_BITS | Source address |
| dstAddr | output | ADDR_BITS | Destination address |
| byteCount | output | 26 | Bytes to transfer |
| simpleStart | output | 1 | One-cycle simple-mode start |
| sgStart | output | 1 | One-cycle scatter-gather start |
| softRst | output | 1 | One-cycle soft reset indication |

## Verification
The bench builds two copies side by side on the same bus stimulus: one with `ADDR_BITS`=64 and one with `ADDR_BITS`=32. Driving both from the same writes shows the two trigger variants in one pass: the same tail-low write fires the start on the narrow copy only, and the tail-high write fires it on the wide copy only. The narrow copy also exposes the missing upper halves, which read zero and drop their writes, while the wide copy stores them.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int IDX_BITS = 4;
  localparam int OFS_BITS = IDX_BITS + 2;
  localparam int BTT_BITS = 26;
  localparam int DESC_ALIGN = 6;

  localparam logic [31:0] CTRL_RESET = 32'h0001_0002;
  localparam logic [31:0] CTRL_KEEP  = 32'hFFFF_707C;

  localparam logic [IDX_BITS-1:0] IDX_CTRL = 4'd0;
  localparam logic [IDX_BITS-1:0] IDX_STAT = 4'd1;
  localparam logic [IDX_BITS-1:0] IDX_CNT  = 4'd10;

  localparam int SOFT_BIT = 2;
  localparam int SG_BIT   = 3;

  typedef struct packed {
    logic                wr;
    logic                rd;
    logic [IDX_BITS-1:0] idx;
    logic [31:0]         data;
  } regStrobe_t;
endpackage

// File: rtl/dmareg_axil_ctrl.sv
module dmareg_axil_ctrl
  import dmareg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                awValid,
  output logic                awReady,
  input  logic [OFS_BITS-1:0] awAddr,
  input  logic                wValid,
  output logic                wReady,
  input  logic [31:0]         wData,
  output logic                bValid,
  input  logic                bReady,
  input  logic                arValid,
  output logic                arReady,
  input  logic [OFS_BITS-1:0] arAddr,
  output logic                rValid,
  input  logic                rReady,
  output regStrobe_t          strb
);
  typedef enum logic [1:0] {S_IDLE, S_BRESP, S_RDATA} busState_t;
  busState_t state;

  logic wrAcc, rdAcc;
  logic unusedLowBits;

  assign unusedLowBits = ^{awAddr[1:0], arAddr[1:0]};

  assign wrAcc   = (state == S_IDLE) && awValid && wValid;
  assign rdAcc   = (state == S_IDLE) && arValid && !(awValid && wValid);
  assign awReady = wrAcc;
  assign wReady  = wrAcc;
  assign arReady = rdAcc;
  assign bValid  = (state == S_BRESP);
  assign rValid  = (state == S_RDATA);

  always_comb begin
    strb.wr   = wrAcc;
    strb.rd   = rdAcc;
    strb.idx  = wrAcc ? awAddr[OFS_BITS-1:2] : arAddr[OFS_BITS-1:2];
    strb.data = wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:  if (wrAcc) state <= S_BRESP; else if (rdAcc) state <= S_RDATA;
        S_BRESP: if (bReady) state <= S_IDLE;
        S_RDATA: if (rReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: responses hold until taken; nothing is accepted while one is open
  p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
  p_rvalid_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid);
  p_busy_noaccept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (bValid || rValid) |-> !(awReady || arReady));
endmodule

// File: rtl/dmareg_datapath.sv
module dmareg_datapath
  import dmareg_pkg::*;
#(
  parameter int ADDR_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic                 engIdle,
  input  logic [2:0]           irqSet,
  input  logic [2:0]           dmaErrSet,
  input  logic [2:0]           sgErrSet,
  input  logic [7:0]           thrCount,
  input  logic [7:0]           dlyCount,
  output logic [31:0]          ctrlWord,
  output logic [ADDR_BITS-1:0] curDesc,
  output logic [ADDR_BITS-1:0] tailDesc,
  output logic [ADDR_BITS-1:0] srcAddr,
  output logic [ADDR_BITS-1:0] dstAddr,
  output logic [BTT_BITS-1:0]  byteCount,
  output logic                 simpleStart,
  output logic                 sgStart,
  output logic                 softRst,
  output logic [31:0]          rdData
);
  localparam bit WIDE     = (ADDR_BITS > 32);
  localparam int NUM_PTRS = 4;

  logic [31:0]          ctrlReg, ctrlNext, statWord, rdNext, hiRead;
  logic [NUM_PTRS-1:0][63:0] ptrBus;
  logic [BTT_BITS-1:0]  bttReg;
  logic [2:0]           irqPend, dmaErr, sgErr, irqClr;
  logic                 ctrlWr, softHit, sgOn, sgOffWr, tailHit;
  logic [7:0]           thrKeep;

  assign ctrlWr  = strb.wr && (strb.idx == IDX_CTRL);
  assign softHit = ctrlWr && strb.data[SOFT_BIT];
  assign sgOn    = ctrlReg[SG_BIT];
  assign sgOffWr = ctrlWr && !softHit && !strb.data[SG_BIT];

  always_comb begin
    thrKeep  = (strb.data[23:16] != 8'd0) ? strb.data[23:16] : ctrlReg[23:16];
    ctrlNext = strb.data & CTRL_KEEP;
    ctrlNext[23:16] = thrKeep;
    ctrlNext[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlReg <= CTRL_RESET;
    else if (softHit) ctrlReg <= CTRL_RESET;
    else if (ctrlWr)  ctrlReg <= ctrlNext;
  end

  // Pointer registers: 0 current, 1 tail, 2 source, 3 destination
  genvar k;
  generate
    for (k = 0; k < NUM_PTRS; k++) begin : g_ptr
      localparam bit IS_DESC = (k < 2);
      localparam logic [IDX_BITS-1:0] LO_IDX = IDX_BITS'(2 + 2 * k);
      localparam logic [IDX_BITS-1:0] HI_IDX = IDX_BITS'(3 + 2 * k);
      logic [63:0] val;
      logic        allow;
      assign allow = !IS_DESC || sgOn;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          val <= '0;
        end else if (softHit || (IS_DESC && sgOffWr)) begin
          val <= '0;
        end else if (strb.wr && allow && strb.idx == LO_IDX) begin
          if (IS_DESC) val[31:0] <= {strb.data[31:DESC_ALIGN], {DESC_ALIGN{1'b0}}};
          else         val[31:0] <= strb.data;
        end else if (WIDE && strb.wr && allow && strb.idx == HI_IDX) begin
          val[63:32] <= strb.data;
        end
      end
      assign ptrBus[k] = val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              bttReg <= '0;
    else if (softHit)                       bttReg <= '0;
    else if (strb.wr && strb.idx == IDX_CNT) bttReg <= strb.data[BTT_BITS-1:0];
  end

  always_comb begin
    irqClr = '0;
    if (strb.wr && strb.idx == IDX_STAT) irqClr = strb.data[14:12];
    if (sgOffWr) irqClr[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend <= '0; dmaErr <= '0; sgErr <= '0;
    end else if (softHit) begin
      irqPend <= '0; dmaErr <= '0; sgErr <= '0;
    end else begin
      irqPend <= (irqPend & ~irqClr) | irqSet;
      dmaErr  <= dmaErr | dmaErrSet;
      sgErr   <= sgErr | sgErrSet;
    end
  end

  assign tailHit = WIDE ? (strb.idx == 4'd5) : (strb.idx == 4'd4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      simpleStart <= 1'b0; sgStart <= 1'b0; softRst <= 1'b0;
    end else begin
      simpleStart <= strb.wr && (strb.idx == IDX_CNT) && !sgOn;
      sgStart     <= strb.wr && sgOn && tailHit;
      softRst     <= softHit;
    end
  end

  assign statWord = {dlyCount, thrCount, 1'b0, irqPend, 1'b0, sgErr, 1'b0, dmaErr,
                     1'b1, 1'b0, engIdle, 1'b0};

  generate
    if (WIDE) begin : g_hi
      always_comb begin
        unique case (strb.idx)
          4'd3:    hiRead = ptrBus[0][63:32];
          4'd5:    hiRead = ptrBus[1][63:32];
          4'd7:    hiRead = ptrBus[2][63:32];
          default: hiRead = ptrBus[3][63:32];
        endcase
      end
    end else begin : g_nohi
      assign hiRead = '0;
    end
  endgenerate

  always_comb begin
    unique case (strb.idx)
      4'd0:                      rdNext = ctrlReg;
      4'd1:                      rdNext = statWord;
      4'd2:                      rdNext = ptrBus[0][31:0];
      4'd4:                      rdNext = ptrBus[1][31:0];
      4'd6:                      rdNext = ptrBus[2][31:0];
      4'd8:                      rdNext = ptrBus[3][31:0];
      4'd3, 4'd5, 4'd7, 4'd9:    rdNext = hiRead;
      4'd10:                     rdNext = {{(32-BTT_BITS){1'b0}}, bttReg};
      default:                   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (strb.rd) rdData <= rdNext;
  end

  assign ctrlWord  = ctrlReg;
  assign curDesc   = ptrBus[0][ADDR_BITS-1:0];
  assign tailDesc  = ptrBus[1][ADDR_BITS-1:0];
  assign srcAddr   = ptrBus[2][ADDR_BITS-1:0];
  assign dstAddr   = ptrBus[3][ADDR_BITS-1:0];
  assign byteCount = bttReg;

  p_thr_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[23:16] != 8'd0);
  p_sgoff_ptrs_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[SG_BIT] |-> (ptrBus[0] == 64'd0 && ptrBus[1] == 64'd0));
  p_desc_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    ptrBus[0][DESC_ALIGN-1:0] == '0 && ptrBus[1][DESC_ALIGN-1:0] == '0);
  p_start_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(simpleStart && sgStart));
  p_sg_start_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    sgStart |-> ctrlReg[SG_BIT]);
  p_softrst_state_r2: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (ctrlReg == CTRL_RESET && bttReg == '0 && irqPend == '0));
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
#(
  parameter int ADDR_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 awValid,
  output logic                 awReady,
  input  logic [OFS_BITS-1:0]  awAddr,
  input  logic                 wValid,
  output logic                 wReady,
  input  logic [31:0]          wData,
  output logic                 bValid,
  input  logic                 bReady,
  output logic [1:0]           bResp,
  input  logic                 arValid,
  output logic                 arReady,
  input  logic [OFS_BITS-1:0]  arAddr,
  output logic                 rValid,
  input  logic                 rReady,
  output logic [31:0]          rData,
  output logic [1:0]           rResp,
  input  logic                 engIdle,
  input  logic [2:0]           irqSet,
  input  logic [2:0]           dmaErrSet,
  input  logic [2:0]           sgErrSet,
  input  logic [7:0]           thrCount,
  input  logic [7:0]           dlyCount,
  output logic [31:0]          ctrlWord,
  output logic [ADDR_BITS-1:0] curDesc,
  output logic [ADDR_BITS-1:0] tailDesc,
  output logic [ADDR_BITS-1:0] srcAddr,
  output logic [ADDR_BITS-1:0] dstAddr,
  output logic [BTT_BITS-1:0]  byteCount,
  output logic                 simpleStart,
  output logic                 sgStart,
  output logic                 softRst
);
  regStrobe_t strb;

  assign bResp = 2'b00;
  assign rResp = 2'b00;

  dmareg_axil_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData),
    .bValid(bValid), .bReady(bReady),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady),
    .strb(strb)
  );

  dmareg_datapath #(.ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .engIdle(engIdle), .irqSet(irqSet), .dmaErrSet(dmaErrSet), .sgErrSet(sgErrSet),
    .thrCount(thrCount), .dlyCount(dlyCount),
    .ctrlWord(ctrlWord), .curDesc(curDesc), .tailDesc(tailDesc),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .byteCount(byteCount),
    .simpleStart(simpleStart), .sgStart(sgStart), .softRst(softRst),
    .rdData(rData)
  );
endmodule

// File: tb/tb_dmareg_top.sv
`timescale 1ns/1ps
module tb_dmareg_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic awValid = 0, wValid = 0, bReady = 0, arValid = 0, rReady = 0;
  logic [5:0] awAddr = 0, arAddr = 0;
  logic [31:0] wData = 0;
  logic engIdle = 1;
  logic [2:0] irqSet = 0, dmaErrSet = 0, sgErrSet = 0;
  logic [7:0] thrCount = 8'd1, dlyCount = 8'd0;

  logic awReadyW, wReadyW, bValidW, arReadyW, rValidW, ssW, sgW, srW;
  logic awReadyN, wReadyN, bValidN, arReadyN, rValidN, ssN, sgN, srN;
  logic [1:0] bRespW, rRespW, bRespN, rRespN;
  logic [31:0] rDataW, rDataN, ctrlW, ctrlN;
  logic [63:0] curW, tailW, srcW, dstW;
  logic [31:0] curN, tailN, srcN, dstN;
  logic [25:0] bttW, bttN;

  dmareg_top #(.ADDR_BITS(64)) dut (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReadyW), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReadyW), .wData(wData), .bValid(bValidW), .bReady(bReady),
    .bResp(bRespW), .arValid(arValid), .arReady(arReadyW), .arAddr(arAddr),
    .rValid(rValidW), .rReady(rReady), .rData(rDataW), .rResp(rRespW),
    .engIdle(engIdle), .irqSet(irqSet), .dmaErrSet(dmaErrSet), .sgErrSet(sgErrSet),
    .thrCount(thrCount), .dlyCount(dlyCount), .ctrlWord(ctrlW), .curDesc(curW),
    .tailDesc(tailW), .srcAddr(srcW), .dstAddr(dstW), .byteCount(bttW),
    .simpleStart(ssW), .sgStart(sgW), .softRst(srW));

  dmareg_top #(.ADDR_BITS(32)) dutNarrow (
    .clk(clk), .rstN(rstN), .awValid(awValid), .awReady(awReadyN), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReadyN), .wData(wData), .bValid(bValidN), .bReady(bReady),
    .bResp(bRespN), .arValid(arValid), .arReady(arReadyN), .arAddr(arAddr),
    .rValid(rValidN), .rReady(rReady), .rData(rDataN), .rResp(rRespN),
    .engIdle(engIdle), .irqSet(irqSet), .dmaErrSet(dmaErrSet), .sgErrSet(sgErrSet),
    .thrCount(thrCount), .dlyCount(dlyCount), .ctrlWord(ctrlN), .curDesc(curN),
    .tailDesc(tailN), .srcAddr(srcN), .dstAddr(dstN), .byteCount(bttN),
    .simpleStart(ssN), .sgStart(sgN), .softRst(srN));

  int nChecks = 0, nFails = 0, cyc = 0;
  bit monOn = 0;

  // Reference model; index 0 = 32-bit copy, 1 = 64-bit copy
  logic [31:0] mCtrl [2];
  logic [63:0] mPtr  [2][4];
  logic [25:0] mBtt  [2];
  logic [2:0]  mIrq [2], mDma [2], mSg [2];
  bit eS [2], eG [2], eR [2];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mReset(input int w);
    mCtrl[w] = 32'h0001_0002;
    for (int p = 0; p < 4; p++) mPtr[w][p] = 64'd0;
    mBtt[w] = 0; mIrq[w] = 0; mDma[w] = 0; mSg[w] = 0;
  endtask

  task automatic mWrite(input int w, input int idx, input logic [31:0] d);
    logic [31:0] t;
    int k; bit hi;
    eS[w] = 0; eG[w] = 0; eR[w] = 0;
    if (idx == 0) begin
      if (d[2]) begin mReset(w); eR[w] = 1; end
      else begin
        t = (d & 32'hFFFF_707C) | 32'h2;
        if (d[23:16] == 8'd0) t[23:16] = mCtrl[w][23:16];
        mCtrl[w] = t;
        if (!t[3]) begin mPtr[w][0] = 0; mPtr[w][1] = 0; mIrq[w][1] = 0; end
      end
    end else if (idx == 1) begin
      mIrq[w] = mIrq[w] & ~d[14:12];
    end else if (idx >= 2 && idx <= 9) begin
      k = (idx - 2) / 2;
      hi = (idx % 2) == 1;
      if (k == 1 && mCtrl[w][3] && ((w == 0 && !hi) || (w == 1 && hi))) eG[w] = 1;
      if (!(k < 2 && !mCtrl[w][3]) && !(hi && w == 0)) begin
        if (hi) mPtr[w][k][63:32] = d;
        else    mPtr[w][k][31:0]  = (k < 2) ? (d & 32'hFFFF_FFC0) : d;
      end
    end else if (idx == 10) begin
      mBtt[w] = d[25:0];
      eS[w] = !mCtrl[w][3];
    end
  endtask

  function automatic logic [31:0] expRead(input int w, input int idx);
    int k;
    if (idx == 0) return mCtrl[w];
    if (idx == 1) return {dlyCount, thrCount, 1'b0, mIrq[w], 1'b0, mSg[w], 1'b0, mDma[w],
                          1'b1, 1'b0, engIdle, 1'b0};
    if (idx >= 2 && idx <= 9) begin
      k = (idx - 2) / 2;
      if (idx % 2 == 1) return (w == 1) ? mPtr[w][k][63:32] : 32'd0;
      return mPtr[w][k][31:0];
    end
    if (idx == 10) return {6'd0, mBtt[w]};
    return 32'd0;
  endfunction

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d, input int holdB, input string tag);
    @(negedge clk);
    awValid = 1; wValid = 1; awAddr = a; wData = d; bReady = 0;
    @(posedge clk);
    for (int w = 0; w < 2; w++) mWrite(w, a[5:2], d);
    @(negedge clk);
    awValid = 0; wValid = 0;
    chk(bValidW && bValidN && bRespW == 0 && bRespN == 0, {tag, " R11 bresp"},
        {bValidW, bValidN, bRespW, bRespN}, 6'b110000);
    for (int i = 0; i < holdB; i++) begin
      @(posedge clk);
      for (int w = 0; w < 2; w++) begin eS[w] = 0; eG[w] = 0; eR[w] = 0; end
      @(negedge clk);
      chk(bValidW && bValidN, {tag, " R11 bvalid hold"}, {bValidW, bValidN}, 2'b11);
    end
    bReady = 1;
    @(posedge clk);
    for (int w = 0; w < 2; w++) begin eS[w] = 0; eG[w] = 0; eR[w] = 0; end
    @(negedge clk);
    bReady = 0;
  endtask

  task automatic busRead(input logic [5:0] a, input string tag);
    logic [31:0] expN, expW;
    @(negedge clk);
    arValid = 1; arAddr = a;
    @(posedge clk);
    @(negedge clk);
    arValid = 0;
    expN = expRead(0, a[5:2]);
    expW = expRead(1, a[5:2]);
    chk(rValidW && rValidN && rRespW == 0 && rRespN == 0, {tag, " R11 rresp"},
        {rValidW, rValidN, rRespW, rRespN}, 6'b110000);
    chk(rDataW === expW, {tag, " wide"}, rDataW, expW);
    chk(rDataN === expN, {tag, " narrow"}, rDataN, expN);
    rReady = 1;
    @(posedge clk);
    @(negedge clk);
    rReady = 0;
  endtask

  task automatic pulseEvents(input logic [2:0] iq, input logic [2:0] de, input logic [2:0] se);
    @(negedge clk);
    irqSet = iq; dmaErrSet = de; sgErrSet = se;
    @(posedge clk);
    for (int w = 0; w < 2; w++) begin
      mIrq[w] = mIrq[w] | iq; mDma[w] = mDma[w] | de; mSg[w] = mSg[w] | se;
    end
    @(negedge clk);
    irqSet = 0; dmaErrSet = 0; sgErrSet = 0;
  endtask

  // Per-clock comparison of strobes and the stored control word
  always @(negedge clk) begin
    if (rstN && monOn) begin
      chk(ssN == eS[0] && ssW == eS[1], "R7 simpleStart", {ssN, ssW}, {eS[0], eS[1]});
      chk(sgN == eG[0] && sgW == eG[1], "R8 sgStart", {sgN, sgW}, {eG[0], eG[1]});
      chk(srN == eR[0] && srW == eR[1], "R2 softRst", {srN, srW}, {eR[0], eR[1]});
      chk(ctrlN == mCtrl[0] && ctrlW == mCtrl[1], "R3 ctrlWord", {ctrlN, ctrlW}, {mCtrl[0], mCtrl[1]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++) begin mReset(w); eS[w] = 0; eG[w] = 0; eR[w] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    monOn = 1;

    busRead(6'h00, "R1 ctrl reset");
    busRead(6'h04, "R1 status reset");

    busWrite(6'h00, 32'hFFFF_FFFB, 0, "R3 mask write");
    busRead(6'h00, "R3 masked ctrl");
    busWrite(6'h00, 32'h0000_0008, 0, "R4 zero thr");
    busRead(6'h00, "R4 thr kept");

    busWrite(6'h08, 32'h1234_567F, 0, "R6 cur lo");
    busRead(6'h08, "R6 cur aligned");
    busWrite(6'h0C, 32'hAABB_CCDD, 0, "R9 cur hi");
    busRead(6'h0C, "R9 cur hi read");
    busWrite(6'h10, 32'h2000_0041, 0, "R8 tail lo");
    busRead(6'h10, "R8 tail lo read");
    busWrite(6'h14, 32'h0000_0001, 0, "R8 tail hi");
    busRead(6'h14, "R8 tail hi read");

    busWrite(6'h18, 32'h89AB_CDEF, 0, "R12 src lo");
    busWrite(6'h1C, 32'h0123_4567, 0, "R12 src hi");
    busWrite(6'h20, 32'h0000_0003, 0, "R12 dst lo");
    busWrite(6'h24, 32'hFEDC_BA98, 0, "R12 dst hi");
    busRead(6'h18, "R12 src lo read");
    busRead(6'h1C, "R12 src hi read");
    busRead(6'h20, "R12 dst lo read");
    busRead(6'h24, "R9 R12 dst hi read");

    busWrite(6'h28, 32'hFFFF_FFFF, 0, "R7 count in sg mode");
    busRead(6'h28, "R7 count width");

    pulseEvents(3'b111, 3'b101, 3'b010);
    busRead(6'h04, "R10 status set");
    busWrite(6'h04, 32'hFFFF_FFFF, 0, "R10 w1c");
    busRead(6'h04, "R10 status after clear");
    pulseEvents(3'b010, 3'b000, 3'b000);
    busRead(6'h04, "R10 delay pending");

    busWrite(6'h00, 32'h0001_0000, 0, "R5 sg off");
    busRead(6'h04, "R5 delay cleared");
    busRead(6'h08, "R5 cur cleared");
    busRead(6'h10, "R5 tail cleared");
    busWrite(6'h08, 32'h0000_1000, 0, "R5 ignored cur");
    busWrite(6'h10, 32'h0000_2000, 0, "R5 ignored tail");
    busRead(6'h08, "R5 cur still zero");
    busRead(6'h10, "R5 tail still zero");
    busWrite(6'h28, 32'h0000_0005, 0, "R7 simple start");
    busRead(6'h28, "R7 count read");

    busRead(6'h2C, "R11 unmapped 2C");
    busRead(6'h3C, "R11 unmapped 3C");
    busWrite(6'h30, 32'hDEAD_BEEF, 3, "R11 unmapped write hold");
    busRead(6'h30, "R11 unmapped 30");

    @(negedge clk);
    engIdle = 0; thrCount = 8'h5A; dlyCount = 8'hC3;
    busRead(6'h04, "R10 live fields");
    @(negedge clk);
    engIdle = 1; thrCount = 8'd1; dlyCount = 8'd0;

    busWrite(6'h00, 32'hFFFF_FFFF, 0, "R2 soft reset");
    busRead(6'h00, "R2 ctrl restored");
    busRead(6'h04, "R2 R1 status restored");
    busRead(6'h18, "R2 src cleared");
    busRead(6'h24, "R2 dst hi cleared");
    busRead(6'h28, "R2 count cleared");

    busWrite(6'h00, 32'h0000_0008, 0, "R4 thr kept from reset");
    busRead(6'h00, "R4 ctrl after reset");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule